// File: doc/BRIEF.md
# SPI Configuration Sequencer

This block runs the complete configuration flow of a target device that accepts its bitstream over a slave SPI port. On a start command it takes the payload length, checks the request, and then steps through a fixed command sequence. It opens in-system programming and reads back a four-byte enable response, which must be zero. It then selects program mode and streams the payload as 16-byte frames. At the end it closes programming, waits a fixed number of cycles, and releases the device. Before each command it polls the device status word through a separate status poller. Each poll reads the status twice, each read in its own chip-select window, and acts on the second read.

The block drives a byte-level SPI engine through a request/acknowledge pair and a chip-select level. It does not shift bits itself. Payload bytes arrive on a valid/ready stream and are taken only while a frame transaction is open. Results are reported on `busy_o`, a one-cycle `done_o`, `prog_mode_o` and a 3-bit `err_o` code: 0 none, 1 poll timeout, 2 status fault, 3 enable failure, 4 bad length, 5 unsupported mode.

Top module: `spi_cfg_seq`

## Requirements
- R1: A start with `partial_i`=1 completes with `err_o`=5 and `done_o` one cycle later, without any chip-select activity.
- R2: A start whose length is not a multiple of 16 completes with `err_o`=4 and `done_o` one cycle later, without any chip-select activity.
- R3: Every command transaction follows at least two single-byte status reads (opcode 0x00). The last status byte read before the command has bit 0 (busy) clear. Before the read-data command, that byte also has bit 1 (ready) set.
- R4: The flow opens with a transaction carrying only 0x0B, then a transaction 0x01 followed by four read bytes. If any of the four bytes is nonzero, the flow stops with `err_o`=3 and program mode is not entered.
- R5: Program mode is selected by one transaction carrying 0x AE then 0x01. `prog_mode_o` rises after it and is high during frame transactions.
- R6: Each frame is its own transaction: 0xEE followed by 16 payload bytes in stream order. There are length/16 such transactions.
- R7: Completion sends a transaction carrying only 0x0C. Chip select then stays inactive for at least GAP_CYC cycles before the next poll, after which a transaction carrying only 0x23 follows. `prog_mode_o` then clears, and `done_o` is reported with `err_o`=0.
- R8: A status byte with bit 2 or bit 3 set stops the flow. The code is 3 if this happens during the enable steps and 2 otherwise.
- R9: A poll that keeps seeing busy for POLL_TMO_CYC cycles stops the flow. The code is 1 if this happens after the enable steps.
- R10: After any error the block is idle with chip select inactive, and `prog_mode_o` keeps its value.
- R11: A length of zero runs the flow with no frame transactions.
- R12: `busy_o` is high whenever chip select is active during a flow, and `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a flow (ignored while busy) |
| partial_i | input | 1 | Request is a partial reconfiguration |
| length_i | input | LEN_W | Payload length in bytes |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Payload byte accepted |
| busy_o | output | 1 | Flow in progress |
| done_o | output | 1 | One-cycle end-of-flow pulse |
| prog_mode_o | output | 1 | Target is in program mode |
| err_o | output | 3 | Result code of the last flow |
| spi_cs_o | output | 1 | Chip select, active high |
| byte_req_o | output | 1 | Byte transfer request |
| byte_tx_o | output | 8 | Byte to send |
| byte_ack_i | input | 1 | Byte transfer done, one cycle |
| byte_rx_i | input | 8 | Byte received, valid with ack |

## Verification
The flow is run with a target model that reports not-busy at once, and with one that stays busy for several reads. Comparing the two separates a poll that waits on the second status read from one that fires a command early. Lengths of 0, 16 and 32 bytes show the frame count following the length. A payload stream with gaps in its valid signal shows that frame bytes keep their order. Faults are injected at two points of the sequence: status fault bits and a stuck busy bit, first inside the enable steps and then after program mode. This tells apart the enable-failure code from the status and timeout codes, and shows that the program-mode flag is kept across an error.

// File: rtl/cfg_seq_pkg.sv
// Package: opcodes, status bit positions, result codes and step names
// shared by the configuration sequencer modules.
package cfg_seq_pkg;

    localparam logic [7:0] OP_STATUS   = 8'h00;
    localparam logic [7:0] OP_READ     = 8'h01;
    localparam logic [7:0] OP_ENABLE   = 8'h0B;
    localparam logic [7:0] OP_DISABLE  = 8'h0C;
    localparam logic [7:0] OP_MODE     = 8'hAE;
    localparam logic [7:0] OP_MODE_ARG = 8'h01;
    localparam logic [7:0] OP_FRAME    = 8'hEE;
    localparam logic [7:0] OP_RELEASE  = 8'h23;

    localparam int FRAME_BYTES = 16;
    localparam int RESP_BYTES  = 4;

    localparam int ST_BUSY  = 0;
    localparam int ST_READY = 1;
    localparam int ST_VIOL  = 2;
    localparam int ST_FAULT = 3;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_TIMEOUT = 3'd1,
        ERR_STATUS  = 3'd2,
        ERR_ENABLE  = 3'd3,
        ERR_LENGTH  = 3'd4,
        ERR_UNSUP   = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        STP_EN, STP_RD, STP_PM, STP_FR, STP_DIS, STP_REL
    } step_e;

endpackage

// File: rtl/cfg_status_poll.sv
// Status poller. On start it reads the target status twice, each read in
// its own chip-select window, and judges the second byte. It finishes with
// ok when busy is clear and all mask bits are set, with a status fault when
// a fault bit is set, or with a timeout after TMO_CYC cycles.
// Assumes the byte engine acknowledges each request exactly once.
module cfg_status_poll
    import cfg_seq_pkg::*;
#(
    parameter int TMO_CYC = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] mask_i,
    output logic       cs_o,
    output logic       req_o,
    input  logic       ack_i,
    input  logic [7:0] rx_i,
    output logic       active_o,
    output logic       done_o,
    output logic       ok_o,
    output err_e       err_o
);

    localparam int TMO_W = $clog2(TMO_CYC + 1);

    typedef enum logic [2:0] {P_IDLE, P_RD1, P_GAP, P_RD2, P_EVAL} pstate_e;

    pstate_e     state_q;
    logic        cs_q;
    logic        done_q;
    logic        ok_q;
    err_e        err_q;
    logic [7:0]  msk_q;
    logic [7:0]  stat_q;
    logic [TMO_W-1:0] tmo_q;
    logic [TMO_W-1:0] tmo_nxt;
    logic        tmo_hit;
    logic        fault;
    logic        pass;

    // Saturating elapsed-cycle count and the decisions on the held status.
    always_comb begin
        tmo_hit = (tmo_q >= TMO_W'(TMO_CYC));
        tmo_nxt = tmo_hit ? tmo_q : tmo_q + 1'b1;
        fault   = stat_q[ST_VIOL] | stat_q[ST_FAULT];
        pass    = ((stat_q & (msk_q | 8'(1 << ST_BUSY))) == msk_q);
    end

    // Read pair sequencing, judgement and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            cs_q    <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            err_q   <= ERR_NONE;
            msk_q   <= '0;
            stat_q  <= '0;
            tmo_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                P_IDLE: if (start_i) begin
                    state_q <= P_RD1;
                    cs_q    <= 1'b1;
                    tmo_q   <= '0;
                    msk_q   <= mask_i;
                end
                P_RD1: begin
                    tmo_q <= tmo_nxt;
                    if (ack_i) begin
                        cs_q    <= 1'b0;
                        state_q <= P_GAP;
                    end
                end
                P_GAP: begin
                    tmo_q   <= tmo_nxt;
                    cs_q    <= 1'b1;
                    state_q <= P_RD2;
                end
                P_RD2: begin
                    tmo_q <= tmo_nxt;
                    if (ack_i) begin
                        stat_q  <= rx_i;
                        cs_q    <= 1'b0;
                        state_q <= P_EVAL;
                    end
                end
                P_EVAL: begin
                    if (fault) begin
                        done_q  <= 1'b1;
                        ok_q    <= 1'b0;
                        err_q   <= ERR_STATUS;
                        state_q <= P_IDLE;
                    end else if (pass) begin
                        done_q  <= 1'b1;
                        ok_q    <= 1'b1;
                        err_q   <= ERR_NONE;
                        state_q <= P_IDLE;
                    end else if (tmo_hit) begin
                        done_q  <= 1'b1;
                        ok_q    <= 1'b0;
                        err_q   <= ERR_TIMEOUT;
                        state_q <= P_IDLE;
                    end else begin
                        tmo_q   <= tmo_nxt;
                        cs_q    <= 1'b1;
                        state_q <= P_RD1;
                    end
                end
                default: state_q <= P_IDLE;
            endcase
        end
    end

    assign cs_o     = cs_q;
    assign req_o    = (state_q == P_RD1) || (state_q == P_RD2);
    assign active_o = (state_q != P_IDLE);
    assign done_o   = done_q;
    assign ok_o     = ok_q;
    assign err_o    = err_q;

    // R3: a status read is only requested inside its chip-select window
    a_r3_read_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> cs_o);

    // R3: a successful poll never reports a status that showed busy
    a_r3_ok_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> !stat_q[ST_BUSY]);

endmodule

// File: rtl/cfg_gap_timer.sv
// Gap timer. Counts while run_i is high and flags expiry in the GAP_CYC-th
// cycle of a run; dropping run_i clears it. Assumes GAP_CYC >= 2.
module cfg_gap_timer #(
    parameter int GAP_CYC = 125_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int GAP_W = $clog2(GAP_CYC + 1);

    logic [GAP_W-1:0] cnt_q;

    // Run-length counter, held at its end value until run_i drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != GAP_W'(GAP_CYC - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == GAP_W'(GAP_CYC - 1));

    // R7: expiry is only seen after the timer was running the cycle before
    a_r7_gap_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(run_i));

endmodule

// File: rtl/cfg_seq_ctrl.sv
// Flow controller. Validates a start request, then walks the command steps
// (enable, read response, program mode, frames, disable, gap, release).
// A status poll runs before every command. It frames each command in its own
// chip-select window and feeds payload bytes into frames one at a time.
// Assumes the poller and gap timer answer on the poll_* and gap_* pins.
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic [LEN_W-1:0] length_i,
    input  logic             pl_valid_i,
    input  logic [7:0]       pl_data_i,
    output logic             pl_ready_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             prog_mode_o,
    output err_e             err_o,
    output logic             cs_o,
    output logic             req_o,
    output logic [7:0]       tx_o,
    input  logic             ack_i,
    input  logic [7:0]       rx_i,
    output logic             poll_start_o,
    output logic [7:0]       poll_mask_o,
    input  logic             poll_done_i,
    input  logic             poll_ok_i,
    input  err_e             poll_err_i,
    output logic             gap_run_o,
    input  logic             gap_expired_i
);

    localparam int FRM_W = LEN_W - 4;
    localparam int IDX_W = $clog2(FRAME_BYTES + 2);

    typedef enum logic [1:0] {C_IDLE, C_POLL, C_XFER, C_GAP} cstate_e;

    cstate_e          state_q;
    step_e            step_q;
    logic [IDX_W-1:0] idx_q;
    logic [FRM_W-1:0] frames_q;
    logic             poll_pend_q;
    logic             cs_q;
    logic [7:0]       hold_q;
    logic             hold_v_q;
    logic             resp_nz_q;
    logic             pmode_q;
    logic             done_q;
    err_e             err_q;

    logic [IDX_W-1:0] len_c;
    logic             last_c;
    logic             slot_c;
    logic             en_phase_c;
    logic             nz_now_c;

    // Transaction length, payload slot and outgoing byte for the current step.
    always_comb begin
        case (step_q)
            STP_RD:  len_c = IDX_W'(RESP_BYTES + 1);
            STP_PM:  len_c = IDX_W'(2);
            STP_FR:  len_c = IDX_W'(FRAME_BYTES + 1);
            default: len_c = IDX_W'(1);
        endcase
        last_c     = (idx_q == len_c - 1'b1);
        slot_c     = (step_q == STP_FR) && (idx_q != '0);
        en_phase_c = (step_q == STP_EN) || (step_q == STP_RD);
        nz_now_c   = resp_nz_q || ((idx_q != '0) && (rx_i != 8'h00));
        case (step_q)
            STP_EN:  tx_o = OP_ENABLE;
            STP_RD:  tx_o = (idx_q == '0) ? OP_READ : 8'h00;
            STP_PM:  tx_o = (idx_q == '0) ? OP_MODE : OP_MODE_ARG;
            STP_FR:  tx_o = (idx_q == '0) ? OP_FRAME : hold_q;
            STP_DIS: tx_o = OP_DISABLE;
            default: tx_o = OP_RELEASE;
        endcase
    end

    assign pl_ready_o   = (state_q == C_XFER) && slot_c && !hold_v_q;
    assign req_o        = (state_q == C_XFER) && (!slot_c || hold_v_q);
    assign poll_start_o = (state_q == C_POLL) && !poll_pend_q;
    assign poll_mask_o  = (step_q == STP_RD) ? 8'(1 << ST_READY) : 8'h00;
    assign gap_run_o    = (state_q == C_GAP);
    assign busy_o       = (state_q != C_IDLE);
    assign done_o       = done_q;
    assign prog_mode_o  = pmode_q;
    assign err_o        = err_q;
    assign cs_o         = cs_q;

    // Step sequencing, transaction framing, payload holding and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= C_IDLE;
            step_q      <= STP_EN;
            idx_q       <= '0;
            frames_q    <= '0;
            poll_pend_q <= 1'b0;
            cs_q        <= 1'b0;
            hold_q      <= '0;
            hold_v_q    <= 1'b0;
            resp_nz_q   <= 1'b0;
            pmode_q     <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                C_IDLE: if (start_i) begin
                    if (partial_i) begin
                        err_q  <= ERR_UNSUP;
                        done_q <= 1'b1;
                    end else if (length_i[3:0] != 4'd0) begin
                        err_q  <= ERR_LENGTH;
                        done_q <= 1'b1;
                    end else begin
                        err_q       <= ERR_NONE;
                        step_q      <= STP_EN;
                        state_q     <= C_POLL;
                        poll_pend_q <= 1'b0;
                        frames_q    <= length_i[LEN_W-1:4];
                        resp_nz_q   <= 1'b0;
                    end
                end
                C_POLL: begin
                    if (!poll_pend_q) begin
                        poll_pend_q <= 1'b1;
                    end else if (poll_done_i) begin
                        poll_pend_q <= 1'b0;
                        if (poll_ok_i) begin
                            state_q  <= C_XFER;
                            cs_q     <= 1'b1;
                            idx_q    <= '0;
                            hold_v_q <= 1'b0;
                        end else begin
                            err_q   <= en_phase_c ? ERR_ENABLE : poll_err_i;
                            done_q  <= 1'b1;
                            state_q <= C_IDLE;
                        end
                    end
                end
                C_XFER: begin
                    if (pl_ready_o && pl_valid_i) begin
                        hold_q   <= pl_data_i;
                        hold_v_q <= 1'b1;
                    end
                    if (req_o && ack_i) begin
                        hold_v_q <= 1'b0;
                        if (step_q == STP_RD) resp_nz_q <= nz_now_c;
                        if (!last_c) begin
                            idx_q <= idx_q + 1'b1;
                        end else begin
                            cs_q    <= 1'b0;
                            state_q <= C_POLL;
                            case (step_q)
                                STP_EN: step_q <= STP_RD;
                                STP_RD: begin
                                    if (nz_now_c) begin
                                        err_q   <= ERR_ENABLE;
                                        done_q  <= 1'b1;
                                        state_q <= C_IDLE;
                                    end else begin
                                        step_q <= STP_PM;
                                    end
                                end
                                STP_PM: begin
                                    pmode_q <= 1'b1;
                                    step_q  <= (frames_q == '0) ? STP_DIS : STP_FR;
                                end
                                STP_FR: begin
                                    frames_q <= frames_q - 1'b1;
                                    step_q   <= (frames_q == FRM_W'(1)) ? STP_DIS : STP_FR;
                                end
                                STP_DIS: begin
                                    step_q  <= STP_REL;
                                    state_q <= C_GAP;
                                end
                                default: begin
                                    pmode_q <= 1'b0;
                                    done_q  <= 1'b1;
                                    state_q <= C_IDLE;
                                end
                            endcase
                        end
                    end
                end
                C_GAP: if (gap_expired_i) state_q <= C_POLL;
                default: state_q <= C_IDLE;
            endcase
        end
    end

    // R1: partial requests end at once with the unsupported code
    a_r1_partial_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && partial_i) |=> (done_o && err_o == ERR_UNSUP && !busy_o));

    // R2: odd lengths end at once with the length code
    a_r2_length_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !partial_i && length_i[3:0] != 4'd0)
        |=> (done_o && err_o == ERR_LENGTH && !busy_o));

    // R5: program mode rises only as a command window closes
    a_r5_mode_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode_o) |-> ($past(cs_o) && !cs_o));

    // R6: payload is taken only inside an open frame window
    a_r6_take_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_ready_o && pl_valid_i) |-> (cs_o && step_q == STP_FR));

    // R7: program mode clears only on a clean completion
    a_r7_mode_clear_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_mode_o) |-> (done_o && err_o == ERR_NONE));

    // R10: every end of flow leaves the block idle with chip select low
    a_r10_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !cs_o));

    // R12: the completion flag lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/spi_cfg_seq.sv
// Top of the SPI configuration sequencer. Joins the flow controller, the
// status poller and the gap timer, and shares one byte-engine port between
// the poller and the controller (only one of them drives it at a time).
module spi_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int GAP_CYC      = 125_000,
    parameter int POLL_TMO_CYC = 250_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic [LEN_W-1:0] length_i,
    input  logic             pl_valid_i,
    input  logic [7:0]       pl_data_i,
    output logic             pl_ready_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             prog_mode_o,
    output logic [2:0]       err_o,
    output logic             spi_cs_o,
    output logic             byte_req_o,
    output logic [7:0]       byte_tx_o,
    input  logic             byte_ack_i,
    input  logic [7:0]       byte_rx_i
);

    logic       c_cs, c_req;
    logic [7:0] c_tx;
    logic       p_cs, p_req, p_active;
    logic       poll_start, poll_done, poll_ok;
    logic [7:0] poll_mask;
    err_e       poll_err;
    err_e       c_err;
    logic       gap_run, gap_expired;

    cfg_seq_ctrl #(.LEN_W(LEN_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .partial_i     (partial_i),
        .length_i      (length_i),
        .pl_valid_i    (pl_valid_i),
        .pl_data_i     (pl_data_i),
        .pl_ready_o    (pl_ready_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .prog_mode_o   (prog_mode_o),
        .err_o         (c_err),
        .cs_o          (c_cs),
        .req_o         (c_req),
        .tx_o          (c_tx),
        .ack_i         (byte_ack_i),
        .rx_i          (byte_rx_i),
        .poll_start_o  (poll_start),
        .poll_mask_o   (poll_mask),
        .poll_done_i   (poll_done),
        .poll_ok_i     (poll_ok),
        .poll_err_i    (poll_err),
        .gap_run_o     (gap_run),
        .gap_expired_i (gap_expired)
    );

    cfg_status_poll #(.TMO_CYC(POLL_TMO_CYC)) i_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (poll_start),
        .mask_i   (poll_mask),
        .cs_o     (p_cs),
        .req_o    (p_req),
        .ack_i    (byte_ack_i),
        .rx_i     (byte_rx_i),
        .active_o (p_active),
        .done_o   (poll_done),
        .ok_o     (poll_ok),
        .err_o    (poll_err)
    );

    cfg_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gap_run),
        .expired_o (gap_expired)
    );

    assign spi_cs_o   = p_cs | c_cs;
    assign byte_req_o = p_req | c_req;
    assign byte_tx_o  = p_active ? OP_STATUS : c_tx;
    assign err_o      = c_err;

    // R3: poller and controller never hold chip select together
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_cs && c_cs));

    // R10: chip select is inactive whenever no flow is running
    a_r10_idle_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !spi_cs_o);

endmodule

// File: tb/test_spi_cfg_seq.sv
// Scoreboard bench: tasks queue the expected command transactions, a
// target model answers byte requests, and a monitor compares each closed
// chip-select window against the queue.
module test_spi_cfg_seq;
    import cfg_seq_pkg::*;

    localparam int LEN_W = 16;
    localparam int GAP   = 40;
    localparam int TMO   = 300;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             partial_i = 1'b0;
    logic [LEN_W-1:0] length_i = '0;
    logic             pl_valid_i = 1'b0;
    logic [7:0]       pl_data_i = '0;
    logic             pl_ready_o, busy_o, done_o, prog_mode_o;
    logic [2:0]       err_o;
    logic             spi_cs_o, byte_req_o;
    logic [7:0]       byte_tx_o;
    logic             byte_ack_i = 1'b0;
    logic [7:0]       byte_rx_i = '0;

    spi_cfg_seq #(.LEN_W(LEN_W), .GAP_CYC(GAP), .POLL_TMO_CYC(TMO)) i_spi_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .length_i(length_i), .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i),
        .pl_ready_o(pl_ready_o), .busy_o(busy_o), .done_o(done_o),
        .prog_mode_o(prog_mode_o), .err_o(err_o), .spi_cs_o(spi_cs_o),
        .byte_req_o(byte_req_o), .byte_tx_o(byte_tx_o),
        .byte_ack_i(byte_ack_i), .byte_rx_i(byte_rx_i)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Target model settings
    int         busy_left = 0;
    int         busy_from = -1;
    int         viol_from = -1;
    int         stat_n = 0;
    logic [7:0] en_resp [4];

    // Scoreboard queues
    logic [7:0] exp_b [$];
    int         exp_l [$];
    string      exp_t [$];

    // Monitor state
    logic [7:0] txn [$];
    logic       cs_prev = 1'b0;
    int         wcnt = 0;
    int         stat_since = 0;
    logic [7:0] last_stat = 8'h00;
    int         cs_rises = 0;
    bit         gap_armed = 0;
    longint     gap_t0 = 0;

    // Payload source
    logic [7:0] pl_mem [64];
    int         pl_idx = 0;
    int         pl_n = 0;
    bit         take_q = 0;
    bit         tog = 0;

    task automatic end_txn();
        int n;
        bit ok;
        logic [7:0] e;
        int bad_i;
        string tag;
        if (txn.size() == 1 && txn[0] == OP_STATUS) begin
            stat_since++;
            return;
        end
        // R3: poll pair before every command, last status not busy
        chk(stat_since >= 2, "R3", "status reads before command", stat_since, 2);
        chk(last_stat[ST_BUSY] == 1'b0, "R3", "busy bit before command", last_stat, 0);
        if (txn[0] == OP_READ)
            chk(last_stat[ST_READY] == 1'b1, "R3", "ready bit before read", last_stat, 2);
        stat_since = 0;
        if (txn[0] == OP_FRAME)
            chk(prog_mode_o == 1'b1, "R5", "program mode during frame", prog_mode_o, 1);
        if (txn[0] == OP_DISABLE && txn.size() == 1) begin
            gap_armed = 1;
            gap_t0 = cyc;
        end
        if (exp_l.size() == 0) begin
            chk(0, "R6", "unexpected transaction opcode", txn[0], 0);
            return;
        end
        n = exp_l.pop_front();
        tag = exp_t.pop_front();
        ok = (n == txn.size());
        bad_i = -1;
        for (int i = 0; i < n; i++) begin
            e = exp_b.pop_front();
            if (ok && txn[i] != e && bad_i < 0) bad_i = i;
        end
        if (!ok) chk(0, tag, "transaction length", txn.size(), n);
        else if (bad_i >= 0) chk(0, tag, $sformatf("byte %0d", bad_i), txn[bad_i], 0);
        else chk(1, tag, "transaction", 0, 0);
    endtask

    // Target model and monitor, away from the active edge
    always @(negedge clk) begin
        logic [7:0] s;
        int idx;
        if (spi_cs_o && !cs_prev) begin
            txn.delete();
            cs_rises++;
            chk(busy_o == 1'b1, "R12", "busy while chip select active", busy_o, 1);
            if (gap_armed) begin
                chk((cyc - gap_t0) >= GAP && (cyc - gap_t0) <= GAP + 3,
                    "R7", "disable-to-release gap", cyc - gap_t0, GAP + 1);
                gap_armed = 0;
            end
        end
        if (!spi_cs_o && cs_prev) end_txn();
        cs_prev = spi_cs_o;
        if (byte_ack_i) begin
            byte_ack_i = 1'b0;
        end else if (byte_req_o) begin
            if (wcnt == 1) begin
                wcnt = 0;
                idx = txn.size();
                byte_rx_i = 8'h00;
                if (idx == 0 && byte_tx_o == OP_STATUS) begin
                    s = 8'h02;
                    if (busy_left > 0) begin s[0] = 1'b1; busy_left--; end
                    if (busy_from >= 0 && stat_n >= busy_from) s[0] = 1'b1;
                    if (viol_from >= 0 && stat_n >= viol_from) s[2] = 1'b1;
                    stat_n++;
                    last_stat = s;
                    byte_rx_i = s;
                end else if (idx >= 1 && idx <= 4 && txn[0] == OP_READ) begin
                    byte_rx_i = en_resp[idx-1];
                end
                txn.push_back(byte_tx_o);
                byte_ack_i = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    // Payload feeder with periodic valid gaps
    always @(negedge clk) begin
        if (take_q) pl_idx++;
        tog = ~tog;
        if (pl_idx < pl_n && (tog || (pl_idx % 4) != 2)) begin
            pl_valid_i = 1'b1;
            pl_data_i  = pl_mem[pl_idx];
        end else begin
            pl_valid_i = 1'b0;
        end
        take_q = pl_valid_i && pl_ready_o;
    end

    task automatic push_txn(input string tag, input int n, input logic [7:0] b0,
                            input logic [7:0] b1);
        exp_l.push_back(n);
        exp_t.push_back(tag);
        exp_b.push_back(b0);
        if (n > 1) exp_b.push_back(b1);
    endtask

    task automatic push_enable();
        push_txn("R4", 1, OP_ENABLE, 8'h00);
        push_txn("R4", 5, OP_READ, 8'h00);
        for (int i = 0; i < 3; i++) exp_b.push_back(8'h00);
    endtask

    task automatic push_frames(input int nf);
        for (int f = 0; f < nf; f++) begin
            push_txn("R6", 17, OP_FRAME, pl_mem[f*16]);
            for (int i = 1; i < 16; i++) exp_b.push_back(pl_mem[f*16+i]);
        end
    endtask

    task automatic push_exit();
        push_txn("R7", 1, OP_DISABLE, 8'h00);
        push_txn("R7", 1, OP_RELEASE, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        busy_left = 0; busy_from = -1; viol_from = -1; stat_n = 0;
        for (int i = 0; i < 4; i++) en_resp[i] = 8'h00;
        exp_b.delete(); exp_l.delete(); exp_t.delete();
        stat_since = 0; gap_armed = 0; cs_rises = 0;
        @(negedge clk);
    endtask

    task automatic prep_payload(input int len, input int seed);
        for (int i = 0; i < len; i++) pl_mem[i] = 8'((i * 7 + seed * 13 + 1) & 8'hFF);
        pl_idx = 0;
        pl_n = len;
    endtask

    logic [2:0] got_err;
    logic       got_pmode;

    task automatic run_flow(input int len, input bit part);
        int wd;
        @(negedge clk);
        length_i  = LEN_W'(len);
        partial_i = part;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wd = 0;
        while (!done_o && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        got_err   = err_o;
        got_pmode = prog_mode_o;
        chk(done_o == 1'b1, "R12", "flow completion seen", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R12", "done single cycle", done_o, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) en_resp[i] = 8'h00;
        do_reset();
        // R10 R12: reset state
        chk(busy_o == 0 && spi_cs_o == 0 && done_o == 0, "R12", "reset busy/cs/done",
            {busy_o, spi_cs_o, done_o}, 0);
        chk(prog_mode_o == 0 && err_o == 0, "R10", "reset mode/err", {prog_mode_o, err_o}, 0);

        // Normal flow, two frames (R4 R5 R6 R7)
        prep_payload(32, 1);
        push_enable(); push_txn("R5", 2, OP_MODE, OP_MODE_ARG); push_frames(2); push_exit();
        run_flow(32, 0);
        chk(got_err == ERR_NONE, "R7", "clean result code", got_err, 0);
        chk(got_pmode == 0, "R7", "program mode cleared", got_pmode, 0);
        chk(exp_l.size() == 0, "R6", "all transactions seen", exp_l.size(), 0);

        // Slow target: busy over several reads (R3)
        do_reset();
        busy_left = 7;
        prep_payload(16, 2);
        push_enable(); push_txn("R5", 2, OP_MODE, OP_MODE_ARG); push_frames(1); push_exit();
        run_flow(16, 0);
        chk(got_err == ERR_NONE, "R3", "busy target result", got_err, 0);
        chk(exp_l.size() == 0, "R3", "all transactions seen", exp_l.size(), 0);

        // Zero length (R11)
        do_reset();
        prep_payload(0, 3);
        push_enable(); push_txn("R5", 2, OP_MODE, OP_MODE_ARG); push_exit();
        run_flow(0, 0);
        chk(got_err == ERR_NONE && exp_l.size() == 0, "R11", "no frames for zero length",
            exp_l.size(), 0);

        // Bad length (R2)
        do_reset();
        run_flow(24, 0);
        chk(got_err == ERR_LENGTH, "R2", "length code", got_err, 4);
        chk(cs_rises == 0, "R2", "no chip select", cs_rises, 0);

        // Partial request (R1)
        do_reset();
        run_flow(16, 1);
        chk(got_err == ERR_UNSUP, "R1", "unsupported code", got_err, 5);
        chk(cs_rises == 0, "R1", "no chip select", cs_rises, 0);

        // Nonzero enable response (R4 R10)
        do_reset();
        en_resp[2] = 8'h01;
        push_enable();
        run_flow(16, 0);
        chk(got_err == ERR_ENABLE, "R4", "enable failure code", got_err, 3);
        chk(got_pmode == 0 && exp_l.size() == 0, "R4", "mode not entered", got_pmode, 0);
        chk(spi_cs_o == 0 && busy_o == 0, "R10", "idle after error", {spi_cs_o, busy_o}, 0);

        // Status fault during enable steps (R8)
        do_reset();
        viol_from = 0;
        run_flow(16, 0);
        chk(got_err == ERR_ENABLE, "R8", "fault in enable steps", got_err, 3);
        chk(cs_rises == 2, "R8", "only the two status reads", cs_rises, 2);

        // Status fault after program mode (R8 R10)
        do_reset();
        viol_from = 6;
        prep_payload(32, 4);
        push_enable(); push_txn("R5", 2, OP_MODE, OP_MODE_ARG);
        run_flow(32, 0);
        chk(got_err == ERR_STATUS, "R8", "status fault code", got_err, 2);
        chk(got_pmode == 1, "R10", "program mode kept", got_pmode, 1);
        chk(exp_l.size() == 0, "R8", "no frame sent", exp_l.size(), 0);

        // Stuck busy after program mode (R9)
        do_reset();
        busy_from = 6;
        prep_payload(16, 5);
        push_enable(); push_txn("R5", 2, OP_MODE, OP_MODE_ARG);
        run_flow(16, 0);
        chk(got_err == ERR_TIMEOUT, "R9", "timeout code", got_err, 1);
        chk(got_pmode == 1 && spi_cs_o == 0, "R10", "mode kept, cs low", got_pmode, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule